// File: doc/BRIEF.md
# Ethernet Burst Frame Generator

This block emits a burst of Ethernet frames, without frame check sequence, on a 64-bit streaming source. A companion MAC downstream is expected to append the FCS. Software uses a small 32-bit register window to set several things before a burst: how many frames to send, whether frame lengths are fixed or drawn at random, and whether the payload is an incrementing byte ramp or pseudorandom data. The same window also holds the destination and source MAC addresses and a 92-bit seed. Writing the launch bit then starts the burst.

Every frame opens with the six destination address bytes, followed by the six source address bytes and then the payload. Random frame lengths and random payload bytes come from a single 92-bit shift-register generator. The generator is reloaded from the seed registers at every launch and moves forward once per accepted beat. A read-only counter shows how many frames have completed. It is cleared by each launch.

Top module: `burst_frame_gen`

## Requirements
- R1: After reset, the three seed registers read back the following values:
  - 0x28 reads 0x5EED0000.
  - 0x2C reads 0x5EED0001.
  - 0x30 reads 0x00025EED.
  - All other registers read 0.
  - The source does not assert valid.
- R2: A read holds waitrequest high for exactly one cycle, and the data is valid in the cycle waitrequest is low. Writes never wait. Stored fields read back masked to their width:
  - 0x34 keeps bits [13:0].
  - 0x18 and 0x20 keep bits [15:0].
  - 0x30 keeps bits [27:0].
  - 0x04 and 0x08 keep bit 0.
- R3: A write with bit 0 set at offset 0x3C, made while idle, launches a burst of N frames, where N is the value at 0x00. A count of zero emits nothing. The launch bit always reads back as 0.
- R4: Launch writes that arrive during a running burst are ignored: the burst neither restarts nor grows.
- R5: Each address occupies two registers:
  - Destination: 0x1C holds bytes 0..3 and 0x20 bits [15:0] hold bytes 4..5.
  - Source: 0x14 holds bytes 0..3 and 0x18 bits [15:0] hold bytes 4..5.
  - Byte k of the low register sits at bits [8k+7:8k]. Byte 0 goes out first.
  - On the stream, frame byte 8b+j is carried in beat b at bits [63-8j:56-8j].
- R6: When bit 0 of 0x04 is 0, every frame is as long as the field at 0x34 [13:0]. A value below 24 is raised to 24, and a value above 9600 is lowered to 9600.
- R7: When bit 0 of 0x04 is 1, each frame's length is 64 + ((S[10:0] * 1455) >> 11), where S is the generator state while that frame's first beat is presented. Every such length lies between 64 and 1518.
- R8: When bit 0 of 0x08 is 0, frame byte p (p >= 12) equals (p - 12) mod 256.
- R9: When bit 0 of 0x08 is 1, frame byte p (p >= 12) on lane j is S[63-8j:56-8j]. The generator state S behaves as follows:
  - At launch, S is loaded with {0x30[27:0], 0x2C, 0x28}.
  - Each accepted beat advances S by 64 single steps of S = {S[90:0], S[91]^S[90]^S[79]^S[78]}.
- R10: Start-of-packet marks the first beat of each frame and end-of-packet marks the last beat. Empty is (8 - len mod 8) mod 8 on the last beat and 0 on every other beat. Byte positions beyond the frame length carry 0.
- R11: While valid is high and ready is low, valid, data, start, end and empty stay unchanged.
- R12: The counter at 0x24 goes up by one for each accepted end-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| csr_read | input | 1 | Register read request |
| csr_write | input | 1 | Register write request |
| csr_addr | input | 8 | Register byte offset |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid when csr_wait is low during a read |
| csr_wait | output | 1 | Waitrequest; stalls a read for one cycle |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Sink ready; a beat transfers when valid and ready are both high |
| tx_data | output | 64 | Beat data, first byte in bits [63:56] |
| tx_sop | output | 1 | First beat of a frame |
| tx_eop | output | 1 | Last beat of a frame |
| tx_empty | output | 3 | Unused bytes in the last beat |

## Verification
The bench aims at three boundary areas:
- Length boundaries: the lower and upper clamps, and lengths that are not a multiple of eight. A mistake in the beat count or in the empty arithmetic would misplace end-of-packet, or leave stray nonzero bytes after the frame.
- Random-length frames, where the length is taken from the generator state at the first beat. A design that latched the length one beat late, or advanced the generator on stalled cycles, would shift every later frame and payload word.
- Control of the burst: a second launch during a running burst, and a burst of zero frames. A wrong design would either restart the burst and emit too many frames, or fail to clear the frame counter.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  localparam int DATA_W    = 64;
  localparam int LANES     = DATA_W / 8;
  localparam int EMPTY_W   = $clog2(LANES);
  localparam int ADDR_W    = 8;
  localparam int LEN_W     = 14;
  localparam int MIN_LEN   = 24;
  localparam int MAX_LEN   = 9600;
  localparam int RLEN_MIN  = 64;
  localparam int RLEN_MAX  = 1518;
  localparam int RLEN_SPAN = RLEN_MAX - RLEN_MIN + 1;
  localparam int RLEN_BITS = 11;
  localparam int PROD_W    = 2 * RLEN_BITS;
  localparam int BEAT_W    = $clog2((MAX_LEN + LANES - 1) / LANES + 1);
  localparam int HDR_BYTES = 12;
  localparam int MAC_W     = 48;
  localparam int PRNG_W    = 92;
  localparam int SEED_HI_W = PRNG_W - 64;

  // feedback taps of the payload generator
  localparam int TAP_A = 91;
  localparam int TAP_B = 90;
  localparam int TAP_C = 79;
  localparam int TAP_D = 78;

  localparam logic [PRNG_W-1:0] SEED_RST = {28'h0025EED, 32'h5EED0001, 32'h5EED0000};

  localparam logic [ADDR_W-1:0] OFS_NFRAMES = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LENMODE = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PAYMODE = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SRC_LO  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SRC_HI  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_DST_LO  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DST_HI  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_SENT    = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_SEED0   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_SEED1   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_SEED2   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_FIXLEN  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_LAUNCH  = 8'h3C;

  typedef struct packed {
    logic [31:0]       n_frames;
    logic              rand_len;
    logic              rand_pay;
    logic [LEN_W-1:0]  fixed_len;
    logic [MAC_W-1:0]  dst;
    logic [MAC_W-1:0]  src;
    logic [PRNG_W-1:0] seed;
  } cfg_t;
endpackage

// File: rtl/bfg_regs.sv
module bfg_regs
  import bfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_read,
  input  logic              csr_write,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              csr_wait,
  input  logic [31:0]       sent_count,
  output cfg_t              cfg,
  output logic              start_req
);
  logic [31:0]       nfr_q, nfr_d;
  logic              rlen_q, rlen_d, rpay_q, rpay_d;
  logic [LEN_W-1:0]  flen_q, flen_d;
  logic [MAC_W-1:0]  dst_q, dst_d, src_q, src_d;
  logic [PRNG_W-1:0] seed_q, seed_d;
  logic              rd_pend_q, rd_pend_d;
  logic [31:0]       rdata_q, rdata_d, rd_mux;
  logic              rd_take;

  // write decode
  always_comb begin
    nfr_d  = nfr_q;
    rlen_d = rlen_q;
    rpay_d = rpay_q;
    flen_d = flen_q;
    dst_d  = dst_q;
    src_d  = src_q;
    seed_d = seed_q;
    if (csr_write) begin
      case (csr_addr)
        OFS_NFRAMES: nfr_d = csr_wdata;
        OFS_LENMODE: rlen_d = csr_wdata[0];
        OFS_PAYMODE: rpay_d = csr_wdata[0];
        OFS_FIXLEN:  flen_d = csr_wdata[LEN_W-1:0];
        OFS_SRC_LO:  src_d[31:0] = csr_wdata;
        OFS_SRC_HI:  src_d[MAC_W-1:32] = csr_wdata[MAC_W-33:0];
        OFS_DST_LO:  dst_d[31:0] = csr_wdata;
        OFS_DST_HI:  dst_d[MAC_W-1:32] = csr_wdata[MAC_W-33:0];
        OFS_SEED0:   seed_d[31:0] = csr_wdata;
        OFS_SEED1:   seed_d[63:32] = csr_wdata;
        OFS_SEED2:   seed_d[PRNG_W-1:64] = csr_wdata[SEED_HI_W-1:0];
        default: ;
      endcase
    end
  end

  // read mux, one wait state
  always_comb begin
    case (csr_addr)
      OFS_NFRAMES: rd_mux = nfr_q;
      OFS_LENMODE: rd_mux = {31'b0, rlen_q};
      OFS_PAYMODE: rd_mux = {31'b0, rpay_q};
      OFS_FIXLEN:  rd_mux = {{(32-LEN_W){1'b0}}, flen_q};
      OFS_SRC_LO:  rd_mux = src_q[31:0];
      OFS_SRC_HI:  rd_mux = {{(64-MAC_W){1'b0}}, src_q[MAC_W-1:32]};
      OFS_DST_LO:  rd_mux = dst_q[31:0];
      OFS_DST_HI:  rd_mux = {{(64-MAC_W){1'b0}}, dst_q[MAC_W-1:32]};
      OFS_SENT:    rd_mux = sent_count;
      OFS_SEED0:   rd_mux = seed_q[31:0];
      OFS_SEED1:   rd_mux = seed_q[63:32];
      OFS_SEED2:   rd_mux = {{(32-SEED_HI_W){1'b0}}, seed_q[PRNG_W-1:64]};
      default:     rd_mux = '0;
    endcase
    rd_take   = csr_read & ~rd_pend_q;
    rd_pend_d = rd_take;
    rdata_d   = rd_take ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nfr_q     <= '0;
      rlen_q    <= 1'b0;
      rpay_q    <= 1'b0;
      flen_q    <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      seed_q    <= SEED_RST;
      rd_pend_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      nfr_q     <= nfr_d;
      rlen_q    <= rlen_d;
      rpay_q    <= rpay_d;
      flen_q    <= flen_d;
      dst_q     <= dst_d;
      src_q     <= src_d;
      seed_q    <= seed_d;
      rd_pend_q <= rd_pend_d;
      rdata_q   <= rdata_d;
    end
  end

  assign csr_wait      = rd_take;
  assign csr_rdata     = rdata_q;
  assign start_req     = csr_write && (csr_addr == OFS_LAUNCH) && csr_wdata[0];
  assign cfg.n_frames  = nfr_q;
  assign cfg.rand_len  = rlen_q;
  assign cfg.rand_pay  = rpay_q;
  assign cfg.fixed_len = flen_q;
  assign cfg.dst       = dst_q;
  assign cfg.src       = src_q;
  assign cfg.seed      = seed_q;
endmodule

// File: rtl/bfg_prng.sv
module bfg_prng
  import bfg_pkg::*;
#(
  parameter int STEPS = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PRNG_W-1:0] seed,
  input  logic              advance,
  output logic [PRNG_W-1:0] state
);
  logic [PRNG_W-1:0] st_q, st_d;

  function automatic logic [PRNG_W-1:0] walk(input logic [PRNG_W-1:0] s);
    logic [PRNG_W-1:0] t;
    t = s;
    for (int i = 0; i < STEPS; i++) begin
      t = {t[PRNG_W-2:0], t[TAP_A] ^ t[TAP_B] ^ t[TAP_C] ^ t[TAP_D]};
    end
    return t;
  endfunction

  always_comb begin
    st_d = st_q;
    if (load)         st_d = seed;
    else if (advance) st_d = walk(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED_RST;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/bfg_framer.sv
module bfg_framer
  import bfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  input  logic               start_req,
  input  logic [DATA_W-1:0]  rnd_word,
  input  logic               tx_ready,
  output logic               tx_valid,
  output logic [DATA_W-1:0]  tx_data,
  output logic               tx_sop,
  output logic               tx_eop,
  output logic [EMPTY_W-1:0] tx_empty,
  output logic               launch,
  output logic               accept,
  output logic [31:0]        sent_count
);
  logic                   busy_q, busy_d;
  logic [31:0]            left_q, left_d;
  logic [BEAT_W-1:0]      beat_q, beat_d;
  logic [LEN_W-1:0]       len_q, len_d;
  logic [31:0]            sent_q, sent_d;
  logic [PROD_W-1:0]      rl_prod;
  logic [LEN_W-1:0]       rand_len, fix_len, new_len, cur_len;
  logic [BEAT_W-1:0]      last_idx;
  logic                   last;
  logic [HDR_BYTES*8-1:0] hdr;

  assign hdr = {cfg.src, cfg.dst};

  // length selection
  always_comb begin
    rl_prod  = {{RLEN_BITS{1'b0}}, rnd_word[RLEN_BITS-1:0]} * PROD_W'(RLEN_SPAN);
    rand_len = LEN_W'(RLEN_MIN) + LEN_W'(rl_prod[PROD_W-1:RLEN_BITS]);
    if (cfg.fixed_len < LEN_W'(MIN_LEN))      fix_len = LEN_W'(MIN_LEN);
    else if (cfg.fixed_len > LEN_W'(MAX_LEN)) fix_len = LEN_W'(MAX_LEN);
    else                                      fix_len = cfg.fixed_len;
    new_len  = cfg.rand_len ? rand_len : fix_len;
    cur_len  = (beat_q == '0) ? new_len : len_q;
    last_idx = BEAT_W'((cur_len + LEN_W'(LANES - 1)) >> EMPTY_W) - BEAT_W'(1);
    last     = (beat_q == last_idx);
  end

  assign launch = start_req & ~busy_q;
  assign accept = busy_q & tx_ready;

  // sequencing
  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    beat_d = beat_q;
    len_d  = len_q;
    sent_d = sent_q;
    if (launch) begin
      busy_d = (cfg.n_frames != '0);
      left_d = cfg.n_frames;
      beat_d = '0;
      sent_d = '0;
    end else if (accept) begin
      if (beat_q == '0) len_d = cur_len;
      if (last) begin
        beat_d = '0;
        left_d = left_q - 32'd1;
        sent_d = sent_q + 32'd1;
        if (left_q == 32'd1) busy_d = 1'b0;
      end else begin
        beat_d = beat_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      beat_q <= '0;
      len_q  <= '0;
      sent_q <= '0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
      beat_q <= beat_d;
      len_q  <= len_d;
      sent_q <= sent_d;
    end
  end

  // byte lanes
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LEN_W-1:0] pos, pay_idx;
    logic [7:0]       b;
    always_comb begin
      pos     = LEN_W'(beat_q) * LEN_W'(LANES) + LEN_W'(j);
      pay_idx = pos - LEN_W'(HDR_BYTES);
      if (pos < LEN_W'(HDR_BYTES)) b = hdr[{pos[3:0], 3'b000} +: 8];
      else if (pos < cur_len)      b = cfg.rand_pay ? rnd_word[DATA_W-1-8*j -: 8] : pay_idx[7:0];
      else                         b = '0;
    end
    assign tx_data[DATA_W-1-8*j -: 8] = b;
  end

  assign tx_valid   = busy_q;
  assign tx_sop     = busy_q & (beat_q == '0);
  assign tx_eop     = busy_q & last;
  assign tx_empty   = (busy_q & last) ? (EMPTY_W'(0) - cur_len[EMPTY_W-1:0]) : '0;
  assign sent_count = sent_q;
endmodule

// File: rtl/burst_frame_gen.sv
module burst_frame_gen
  import bfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_read,
  input  logic               csr_write,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  output logic               csr_wait,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [DATA_W-1:0]  tx_data,
  output logic               tx_sop,
  output logic               tx_eop,
  output logic [EMPTY_W-1:0] tx_empty
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  cfg_t              cfg;
  logic              start_req, launch, accept;
  logic [31:0]       sent_count;
  logic [PRNG_W-1:0] prng_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  bfg_regs u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .csr_read(csr_read), .csr_write(csr_write), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_wait(csr_wait),
    .sent_count(sent_count), .cfg(cfg), .start_req(start_req)
  );

  bfg_prng #(.STEPS(DATA_W)) u_prng (
    .clk(clk), .rst_n(rst_core_n), .load(launch), .seed(cfg.seed),
    .advance(accept), .state(prng_state)
  );

  bfg_framer u_framer (
    .clk(clk), .rst_n(rst_core_n), .cfg(cfg), .start_req(start_req),
    .rnd_word(prng_state[DATA_W-1:0]), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_empty(tx_empty), .launch(launch), .accept(accept), .sent_count(sent_count)
  );
endmodule

// File: rtl/bfg_checker.sv
module bfg_checker
  import bfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               csr_read,
  input logic               csr_wait,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [DATA_W-1:0]  tx_data,
  input logic               tx_sop,
  input logic               tx_eop,
  input logic [EMPTY_W-1:0] tx_empty
);
  logic             in_pkt_q;
  logic [LEN_W:0]   bytes_q;
  logic [LEN_W:0]   seen, total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      bytes_q  <= '0;
    end else if (tx_valid && tx_ready) begin
      in_pkt_q <= !tx_eop;
      bytes_q  <= tx_eop ? '0 : (seen + (LEN_W+1)'(LANES));
    end
  end

  always_comb begin
    seen  = tx_sop ? '0 : bytes_q;
    total = seen + (LEN_W+1)'(LANES) - (LEN_W+1)'(tx_empty);
  end

  a_r11_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop)
                              && $stable(tx_eop) && $stable(tx_empty));
  a_r10_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> !in_pkt_q);
  a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_sop |-> in_pkt_q);
  a_r10_empty_last_only: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_eop |-> tx_empty == '0);
  a_r6_len_window: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_eop |-> (total >= (LEN_W+1)'(MIN_LEN)) && (total <= (LEN_W+1)'(MAX_LEN)));
  a_r2_read_wait_one: assert property (@(posedge clk) disable iff (!rst_n)
    csr_read && csr_wait |=> !csr_wait);
endmodule

bind burst_frame_gen bfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .csr_read(csr_read), .csr_wait(csr_wait),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty)
);

// File: tb/burst_frame_gen_bench.sv
`timescale 1ns/1ps
module burst_frame_gen_bench;
  typedef struct packed {
    logic [63:0] d;
    logic        s;
    logic        e;
    logic [2:0]  m;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_read, csr_write;
  logic [7:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        csr_wait;
  logic        tx_valid, tx_ready, tx_sop, tx_eop;
  logic [63:0] tx_data;
  logic [2:0]  tx_empty;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    rdy_rand = 1'b0;
  string cur_req = "R10";
  beat_t exp_q[$];
  beat_t cur_b, exp_b, prev_b;
  bit    prev_stall = 1'b0;
  logic [7:0]  dst_b[6];
  logic [7:0]  src_b[6];
  logic [91:0] seed_m = {28'h0025EED, 32'h5EED0001, 32'h5EED0000};

  always #2 clk = ~clk;

  burst_frame_gen u_burst_frame_gen (
    .clk(clk), .rst_n(rst_n), .csr_read(csr_read), .csr_write(csr_write),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_wait(csr_wait), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [91:0] step64(input logic [91:0] s);
    logic [91:0] t = s;
    for (int i = 0; i < 64; i++) t = {t[90:0], t[91] ^ t[90] ^ t[79] ^ t[78]};
    return t;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_write = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bit got = 1'b0;
    @(posedge clk); #1;
    csr_read = 1'b1; csr_addr = a;
    while (!got) begin
      @(negedge clk);
      if (!csr_wait) begin d = csr_rdata; got = 1'b1; end
    end
    @(posedge clk); #1;
    csr_read = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    rd(a, d);
    check(d == e, req, $sformatf("read 0x%02h", a), d, e);
  endtask

  // expected beats of a burst, from R5..R10
  task automatic push_burst(input int n, input bit rl, input bit rp, input int flen);
    logic [91:0] s = seed_m;
    int len, nb, p, f14;
    beat_t b;
    logic [7:0] v;
    f14 = flen & 16383;
    for (int f = 0; f < n; f++) begin
      if (rl) len = 64 + ((int'(s[10:0]) * 1455) >> 11);
      else    len = (f14 < 24) ? 24 : ((f14 > 9600) ? 9600 : f14);
      nb = (len + 7) / 8;
      for (int k = 0; k < nb; k++) begin
        for (int j = 0; j < 8; j++) begin
          p = k * 8 + j;
          if (p < 6)         v = dst_b[p];
          else if (p < 12)   v = src_b[p-6];
          else if (p < len)  v = rp ? s[63-8*j -: 8] : 8'((p - 12) % 256);
          else               v = 8'h00;
          b.d[63-8*j -: 8] = v;
        end
        b.s = (k == 0);
        b.e = (k == nb - 1);
        b.m = b.e ? 3'((8 - len % 8) % 8) : 3'd0;
        exp_q.push_back(b);
        s = step64(s);
      end
    end
  endtask

  task automatic set_seed(input logic [91:0] s);
    wr(8'h28, s[31:0]);
    wr(8'h2C, s[63:32]);
    wr(8'h30, {4'h0, s[91:64]});
    seed_m = s;
  endtask

  task automatic burst(input int n, input bit rl, input bit rp, input int flen,
                       input bit rdy, input bit poke, input string req);
    logic [31:0] d;
    rdy_rand = rdy;
    cur_req  = req;
    wr(8'h00, n);
    wr(8'h04, {31'b0, rl});
    wr(8'h08, {31'b0, rp});
    wr(8'h34, flen);
    push_burst(n, rl, rp, flen);
    wr(8'h3C, 32'h1);
    if (poke) begin
      repeat (6) @(posedge clk);
      wr(8'h3C, 32'h1);          // R4: ignored while running
    end
    while (exp_q.size() != 0) @(posedge clk);
    repeat (30) @(posedge clk);
    rd(8'h24, d);
    check(d == n, poke ? "R4" : "R12", "frames sent counter", d, n);
  endtask

  // sink ready pattern
  always @(posedge clk) begin
    #1;
    tx_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cur_b = {tx_data, tx_sop, tx_eop, tx_empty};
      if (prev_stall)
        check(tx_valid && (cur_b == prev_b), "R11", "held beat under stall", cur_b, prev_b);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected beat", cur_b, 0);
        end else begin
          exp_b = exp_q.pop_front();
          check(cur_b == exp_b, cur_req, "beat content", cur_b, exp_b);
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_b     = cur_b;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; csr_read = 1'b0; csr_write = 1'b0; csr_addr = '0; csr_wdata = '0;
    tx_ready = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    check(tx_valid == 1'b0, "R1", "valid after reset", tx_valid, 0);
    rd_check(8'h28, 32'h5EED0000, "R1");
    rd_check(8'h2C, 32'h5EED0001, "R1");
    rd_check(8'h30, 32'h00025EED, "R1");
    rd_check(8'h24, 32'h0, "R1");
    rd_check(8'h00, 32'h0, "R1");
    rd_check(8'h34, 32'h0, "R1");

    // R2 masks
    wr(8'h34, 32'hFFFF_FFFF); rd_check(8'h34, 32'h0000_3FFF, "R2");
    wr(8'h18, 32'hFFFF_FFFF); rd_check(8'h18, 32'h0000_FFFF, "R2");
    wr(8'h30, 32'hFFFF_FFFF); rd_check(8'h30, 32'h0FFF_FFFF, "R2");
    wr(8'h04, 32'hFFFF_FFFF); rd_check(8'h04, 32'h1, "R2");
    wr(8'h30, 32'h0002_5EED);
    wr(8'h00, 32'h0);
    wr(8'h3C, 32'h1);
    rd_check(8'h3C, 32'h0, "R3");

    // R5 addresses: dst 00-1C-23-17-4A-CB, src 02-A0-B1-C2-D3-E4
    dst_b = '{8'h00, 8'h1C, 8'h23, 8'h17, 8'h4A, 8'hCB};
    src_b = '{8'h02, 8'hA0, 8'hB1, 8'hC2, 8'hD3, 8'hE4};
    wr(8'h1C, {dst_b[3], dst_b[2], dst_b[1], dst_b[0]});
    wr(8'h20, {16'h0, dst_b[5], dst_b[4]});
    wr(8'h14, {src_b[3], src_b[2], src_b[1], src_b[0]});
    wr(8'h18, {16'h0, src_b[5], src_b[4]});
    rd_check(8'h1C, 32'h17231C00, "R5");
    rd_check(8'h20, 32'h0000CB4A, "R5");

    burst(3, 1'b0, 1'b0, 24,    1'b0, 1'b0, "R8");   // shortest legal, ramp payload
    burst(2, 1'b0, 1'b0, 61,    1'b1, 1'b0, "R10");  // empty = 3, stalls
    burst(1, 1'b0, 1'b0, 10,    1'b1, 1'b0, "R6");   // raised to 24
    burst(1, 1'b0, 1'b0, 16000, 1'b1, 1'b0, "R6");   // lowered to 9600
    burst(4, 1'b1, 1'b1, 0,     1'b1, 1'b0, "R7");   // random length, default seed
    set_seed({28'h0ABCDEF, 32'h9ABCDEF0, 32'h12345678});
    burst(2, 1'b0, 1'b1, 203,   1'b1, 1'b0, "R9");   // random payload, new seed
    burst(3, 1'b0, 1'b0, 100,   1'b1, 1'b1, "R4");   // relaunch while running

    // R3 zero-frame burst clears counter, emits nothing
    burst(0, 1'b0, 1'b0, 64,    1'b1, 1'b0, "R3");
    check(tx_valid == 1'b0, "R3", "valid after empty burst", tx_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule